// File: doc/BRIEF.md
# Serial Display Power-On Sequencer

This block brings a small display controller out of power-on without help from a processor. As soon as its own reset is released, it drives a scripted pulse on the panel reset line: high, then low, then high again. It then works through a fixed table of 38 register writes. Each write goes out over a 3-wire serial link with an active-low chip select. Every write is two 24-bit frames: the register index first, then the 16-bit value. Some entries ask for a pause in milliseconds after their value frame. When the last entry has gone out, the block raises a display-enable output and reports that it is done.

One counter times every wait. That covers the three reset phases, the per-entry pauses and the short idle gaps between frames. A parameter gives the number of system clock cycles in one millisecond, and a second parameter sets the serial clock half-period in system clock cycles. A start pulse given after completion runs the whole sequence again. A start pulse given while the block is busy is ignored.

Top module: `lcd_bringup_seq`

## Requirements
- R1: From the first clock edge with `rst_n` high, or from the edge after the one that samples `start` in the done state, `panel_rst_n` stays high for 100 ms. It then goes low for exactly 20 ms, then high again, and the first chip-select fall comes exactly 20 ms after that rise (1 ms = `CLK_PER_MS` cycles).
- R2: Each frame is 24 bits, sent most significant bit first. `spi_cs_n` stays low for exactly 48*`SCK_HALF` cycles. `spi_sck` rises 24 times while `spi_cs_n` is low, and `spi_sdo` changes only while `spi_sck` is low, so it is steady at each rising edge.
- R3: Every table entry produces an index frame and then a value frame. The index frame is 0x74, 0x00, then the 8-bit register index. The value frame is 0x76, the value's upper byte, then its lower byte.
- R4: The table has 38 entries, sent in a fixed order. Register 0x07 is written 0x0000 first. Near the end it is written 0x0015 and then 0x0017. The final entry writes 0x0000 to register 0x22. Non-zero pauses of 10, 50, 200 and 30 ms follow entries 1, 5, 7 and 33.
- R5: After a value frame whose entry has a pause d > 0, `spi_cs_n` stays high for exactly d*`CLK_PER_MS` cycles. After any other frame it stays high for exactly 2*`SCK_HALF` cycles.
- R6: `done` and `disp_en` rise exactly 2*`SCK_HALF` cycles after the last frame ends, and only once all 76 frames have been sent. They then stay high, with `busy` low and `spi_cs_n` high.
- R7: `busy` is high from reset release, or from a restart, until `done` rises, and `done` stays low for that whole time.
- R8: A `start` pulse while `busy` is high has no effect. The reset phase and the frame sequence carry on unchanged.
- R9: A `start` pulse while `done` is high clears `done` and `disp_en` on the next cycle, raises `busy`, and reruns the whole sequence from R1.
- R10: While `spi_cs_n` is high, `spi_sck` and `spi_sdo` are both low. During `rst_n` low, the outputs are `spi_cs_n`=1, `spi_sck`=0, `done`=0, `disp_en`=0, `busy`=1 and `panel_rst_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts the sequence |
| start | input | 1 | Restart request, acted on only when done |
| panel_rst_n | output | 1 | Reset line to the display controller |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |
| disp_en | output | 1 | Display enable, high after the last entry |

## Verification
The bench builds the block with `CLK_PER_MS` = 8 and `SCK_HALF` = 2. A 200 ms pause then shrinks to 1600 cycles, so two full runs of all 76 frames, every pause and every reset phase fit into a short simulation. The bench checks every phase to the exact cycle rather than by range. The small half-period also means off-by-one errors in the divider or the bit count change frame lengths by a visible amount. Random start pulses land in every phase, including the reset-low phase, and a directed restart after completion exercises the rerun path.

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq #(
  parameter int CLK_PER_MS    = 100000,
  parameter int SCK_HALF      = 4,
  parameter int RST_HIGH_MS   = 100,
  parameter int RST_LOW_MS    = 20,
  parameter int RST_SETTLE_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic panel_rst_n,
  output logic spi_cs_n,
  output logic spi_sck,
  output logic spi_sdo,
  output logic busy,
  output logic done,
  output logic disp_en
);
  localparam int N_ENT  = 38;
  localparam int IW     = $clog2(N_ENT);
  localparam int MAX_MS = 200;
  localparam int CW     = $clog2(MAX_MS * CLK_PER_MS + 1);
  localparam int DW     = $clog2(SCK_HALF + 1);

  typedef enum logic [2:0] {S_RHI, S_RLO, S_RSET, S_FRAME, S_GAP, S_DELAY, S_DONE} st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic           second;
  logic [23:0]    sh;
  logic [4:0]     bits;
  logic [DW-1:0]  div;

  function automatic logic [31:0] entry(input logic [IW-1:0] i);
    case (i)
      6'd0:  entry = {8'h07, 16'h0000, 8'd0};
      6'd1:  entry = {8'h13, 16'h0000, 8'd10};
      6'd2:  entry = {8'h11, 16'h3004, 8'd0};
      6'd3:  entry = {8'h14, 16'h200F, 8'd0};
      6'd4:  entry = {8'h10, 16'h1A20, 8'd0};
      6'd5:  entry = {8'h13, 16'h0040, 8'd50};
      6'd6:  entry = {8'h13, 16'h0060, 8'd0};
      6'd7:  entry = {8'h13, 16'h0070, 8'd200};
      6'd8:  entry = {8'h01, 16'h0127, 8'd0};
      6'd9:  entry = {8'h02, 16'h0700, 8'd0};
      6'd10: entry = {8'h03, 16'h1030, 8'd0};
      6'd11: entry = {8'h08, 16'h0208, 8'd0};
      6'd12: entry = {8'h0B, 16'h0620, 8'd0};
      6'd13: entry = {8'h0C, 16'h0110, 8'd0};
      6'd14: entry = {8'h30, 16'h0120, 8'd0};
      6'd15: entry = {8'h31, 16'h0127, 8'd0};
      6'd16: entry = {8'h32, 16'h0000, 8'd0};
      6'd17: entry = {8'h33, 16'h0503, 8'd0};
      6'd18: entry = {8'h34, 16'h0727, 8'd0};
      6'd19: entry = {8'h35, 16'h0124, 8'd0};
      6'd20: entry = {8'h36, 16'h0706, 8'd0};
      6'd21: entry = {8'h37, 16'h0701, 8'd0};
      6'd22: entry = {8'h38, 16'h0F00, 8'd0};
      6'd23: entry = {8'h39, 16'h0F00, 8'd0};
      6'd24: entry = {8'h40, 16'h0000, 8'd0};
      6'd25: entry = {8'h41, 16'h0000, 8'd0};
      6'd26: entry = {8'h42, 16'h013F, 8'd0};
      6'd27: entry = {8'h43, 16'h0000, 8'd0};
      6'd28: entry = {8'h44, 16'h013F, 8'd0};
      6'd29: entry = {8'h45, 16'h0000, 8'd0};
      6'd30: entry = {8'h46, 16'hEF00, 8'd0};
      6'd31: entry = {8'h47, 16'h013F, 8'd0};
      6'd32: entry = {8'h48, 16'h0000, 8'd0};
      6'd33: entry = {8'h07, 16'h0015, 8'd30};
      6'd34: entry = {8'h07, 16'h0017, 8'd0};
      6'd35: entry = {8'h20, 16'h0000, 8'd0};
      6'd36: entry = {8'h21, 16'h0000, 8'd0};
      6'd37: entry = {8'h22, 16'h0000, 8'd0};
      default: entry = 32'h0;
    endcase
  endfunction

  function automatic logic [CW-1:0] ms_cycles(input int ms);
    return CW'(ms * CLK_PER_MS - 1);
  endfunction

  logic [31:0]   cur, nxt;
  logic [IW-1:0] idx_nx;
  logic          last;

  assign idx_nx = idx + 1'b1;
  assign cur    = entry(idx);
  assign nxt    = entry(idx_nx);
  assign last   = (idx == IW'(N_ENT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_RHI;
      cnt     <= ms_cycles(RST_HIGH_MS);
      idx     <= '0;
      second  <= 1'b0;
      sh      <= '0;
      bits    <= '0;
      div     <= '0;
      spi_sck <= 1'b0;
      spi_cs_n <= 1'b1;
      disp_en <= 1'b0;
    end else begin
      case (state)
        S_RHI: begin
          if (cnt == '0) begin
            state <= S_RLO;
            cnt   <= ms_cycles(RST_LOW_MS);
          end else cnt <= cnt - 1'b1;
        end
        S_RLO: begin
          if (cnt == '0) begin
            state <= S_RSET;
            cnt   <= ms_cycles(RST_SETTLE_MS);
          end else cnt <= cnt - 1'b1;
        end
        S_RSET: begin
          if (cnt == '0) begin
            state    <= S_FRAME;
            sh       <= {8'h74, 8'h00, cur[31:24]};
            second   <= 1'b0;
            spi_cs_n <= 1'b0;
            bits     <= '0;
            div      <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_FRAME: begin
          if (div == DW'(SCK_HALF - 1)) begin
            div <= '0;
            if (!spi_sck) spi_sck <= 1'b1;
            else begin
              spi_sck <= 1'b0;
              if (bits == 5'd23) begin
                spi_cs_n <= 1'b1;
                if (second && cur[7:0] != 8'd0) begin
                  state <= S_DELAY;
                  cnt   <= ms_cycles(int'(cur[7:0]));
                end else begin
                  state <= S_GAP;
                  cnt   <= CW'(2 * SCK_HALF - 1);
                end
              end else begin
                sh   <= {sh[22:0], 1'b0};
                bits <= bits + 1'b1;
              end
            end
          end else div <= div + 1'b1;
        end
        S_GAP, S_DELAY: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (state == S_GAP && !second) begin
            state    <= S_FRAME;
            sh       <= {8'h76, cur[23:8]};
            second   <= 1'b1;
            spi_cs_n <= 1'b0;
            bits     <= '0;
            div      <= '0;
          end else if (last) begin
            state   <= S_DONE;
            disp_en <= 1'b1;
          end else begin
            state    <= S_FRAME;
            idx      <= idx_nx;
            sh       <= {8'h74, 8'h00, nxt[31:24]};
            second   <= 1'b0;
            spi_cs_n <= 1'b0;
            bits     <= '0;
            div      <= '0;
          end
        end
        default: begin
          if (start) begin
            state   <= S_RHI;
            cnt     <= ms_cycles(RST_HIGH_MS);
            idx     <= '0;
            disp_en <= 1'b0;
          end
        end
      endcase
    end
  end

  assign panel_rst_n = (state != S_RLO);
  assign spi_sdo     = !spi_cs_n && sh[23];
  assign busy        = (state != S_DONE);
  assign done        = (state == S_DONE);
endmodule

// File: rtl/lcd_bringup_seq_chk.sv
module lcd_bringup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic panel_rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_sdo,
  input logic busy,
  input logic done,
  input logic disp_en
);
  a_r2_sdo_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $rose(spi_sck)) |-> $stable(spi_sdo));

  a_r10_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (!spi_sck && !spi_sdo));

  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  a_r1_no_frame_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> spi_cs_n);

  a_r6_enable_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (done && spi_cs_n));

  a_r7_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !disp_en);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !panel_rst_n) |=> !panel_rst_n);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (busy && !disp_en));
endmodule

bind lcd_bringup_seq lcd_bringup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .panel_rst_n(panel_rst_n),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdo(spi_sdo),
  .busy(busy), .done(done), .disp_en(disp_en)
);

// File: tb/lcd_bringup_seq_tb.sv
`timescale 1ns/1ps
module lcd_bringup_seq_tb_top;
  localparam int CPM = 8;
  localparam int H   = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic panel_rst_n, spi_cs_n, spi_sck, spi_sdo, busy, done, disp_en;

  always #2.5 clk = ~clk;

  lcd_bringup_seq #(.CLK_PER_MS(CPM), .SCK_HALF(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .panel_rst_n(panel_rst_n),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdo(spi_sdo),
    .busy(busy), .done(done), .disp_en(disp_en));

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  longint t_start, t_rfall, t_rrise, t_csfall, t_csrise;
  int fidx, nb;
  logic [23:0] frm;
  logic p_rst, p_cs, p_sck, p_done, mon_on;

  function automatic logic [31:0] tab(input int i);
    logic [31:0] t;
    case (i)
      0: t = 32'h07_0000_00;  1: t = 32'h13_0000_0A;  2: t = 32'h11_3004_00;
      3: t = 32'h14_200F_00;  4: t = 32'h10_1A20_00;  5: t = 32'h13_0040_32;
      6: t = 32'h13_0060_00;  7: t = 32'h13_0070_C8;  8: t = 32'h01_0127_00;
      9: t = 32'h02_0700_00; 10: t = 32'h03_1030_00; 11: t = 32'h08_0208_00;
      12: t = 32'h0B_0620_00; 13: t = 32'h0C_0110_00; 14: t = 32'h30_0120_00;
      15: t = 32'h31_0127_00; 16: t = 32'h32_0000_00; 17: t = 32'h33_0503_00;
      18: t = 32'h34_0727_00; 19: t = 32'h35_0124_00; 20: t = 32'h36_0706_00;
      21: t = 32'h37_0701_00; 22: t = 32'h38_0F00_00; 23: t = 32'h39_0F00_00;
      24: t = 32'h40_0000_00; 25: t = 32'h41_0000_00; 26: t = 32'h42_013F_00;
      27: t = 32'h43_0000_00; 28: t = 32'h44_013F_00; 29: t = 32'h45_0000_00;
      30: t = 32'h46_EF00_00; 31: t = 32'h47_013F_00; 32: t = 32'h48_0000_00;
      33: t = 32'h07_0015_1E; 34: t = 32'h07_0017_00; 35: t = 32'h20_0000_00;
      36: t = 32'h21_0000_00; 37: t = 32'h22_0000_00;
      default: t = 32'h0;
    endcase
    return t;
  endfunction

  function automatic logic [23:0] exp_frame(input int f);
    logic [31:0] e = tab(f / 2);
    return (f % 2 == 0) ? {8'h74, 8'h00, e[31:24]} : {8'h76, e[23:8]};
  endfunction

  function automatic longint exp_gap(input int f);
    logic [31:0] e = tab(f / 2);
    return (f % 2 == 1 && e[7:0] != 0) ? longint'(e[7:0]) * CPM : longint'(2 * H);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_rst && !panel_rst_n) begin
        chk(cyc - t_start == 100 * CPM, "R1", "reset high time", cyc - t_start, 100 * CPM);
        t_rfall = cyc;
      end
      if (!p_rst && panel_rst_n) begin
        chk(cyc - t_rfall == 20 * CPM, "R1", "reset low time", cyc - t_rfall, 20 * CPM);
        t_rrise = cyc;
      end
      if (p_cs && !spi_cs_n) begin
        if (fidx == 0)
          chk(cyc - t_rrise == 20 * CPM, "R1", "settle before first frame", cyc - t_rrise, 20 * CPM);
        else
          chk(cyc - t_csrise == exp_gap(fidx - 1), "R5", "gap after frame", cyc - t_csrise, exp_gap(fidx - 1));
        chk(busy && !done, "R7", "busy during sequence", {busy, done}, 2'b10);
        nb = 0; t_csfall = cyc;
      end
      if (!spi_cs_n && !p_sck && spi_sck) begin
        frm = {frm[22:0], spi_sdo};
        nb++;
      end
      if (!p_cs && spi_cs_n) begin
        chk(nb == 24, "R2", "rising edges per frame", nb, 24);
        chk(cyc - t_csfall == 48 * H, "R2", "frame length", cyc - t_csfall, 48 * H);
        chk(frm == exp_frame(fidx), (fidx % 2 == 0) ? "R3" : "R4", "frame content", frm, exp_frame(fidx));
        fidx++; t_csrise = cyc;
      end
      if (!p_done && done) begin
        chk(fidx == 76, "R6", "frames before done", fidx, 76);
        chk(cyc - t_csrise == 2 * H, "R6", "done delay", cyc - t_csrise, 2 * H);
        chk(disp_en && !busy && spi_cs_n, "R6", "enable state", {disp_en, busy, spi_cs_n}, 3'b101);
      end
      if (spi_cs_n)
        if (spi_sck || spi_sdo) chk(0, "R10", "idle lines", {spi_sck, spi_sdo}, 0);
    end
    p_rst = panel_rst_n; p_cs = spi_cs_n; p_sck = spi_sck; p_done = done;
  end

  task automatic run_to_done();
    while (!done) begin
      @(negedge clk);
      if (!done && ($urandom % 211) == 0) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    mon_on = 1'b0; fidx = 0; nb = 0; frm = '0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !done && !disp_en && busy && panel_rst_n,
        "R10", "reset outputs", {spi_cs_n, spi_sck, done, disp_en, busy, panel_rst_n}, 6'b100011);
    p_rst = 1'b1; p_cs = 1'b1; p_sck = 1'b0; p_done = 1'b0;
    rst_n = 1'b1; t_start = cyc; mon_on = 1'b1;
    while (panel_rst_n) @(negedge clk);
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(!panel_rst_n && busy, "R8", "start in reset-low ignored", {panel_rst_n, busy}, 2'b01);
    run_to_done();
    repeat (5 + $urandom % 16) @(negedge clk);
    chk(done && disp_en && spi_cs_n, "R6", "done holds", {done, disp_en, spi_cs_n}, 3'b111);
    start = 1'b1; t_start = cyc + 1; fidx = 0;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !disp_en, "R9", "restart", {busy, done, disp_en}, 3'b100);
    run_to_done();
    chk(fidx == 76, "R9", "second run frames", fidx, 76);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule